// File: doc/BRIEF.md
# Power-of-Four Oversampling Averager

This block builds one higher-resolution reading from a run of 4, 16, 64 or 256 back-to-back 12-bit conversions. A start trigger clears the running sum and asks the converter for the first sample. Each later sample is requested in one of two ways. In paced mode, every step trigger asks for one more sample. In burst mode, the block asks for the next sample as soon as the previous result arrives, and it raises a hold line so that an arbiter keeps other channels off the converter.

When the last sample of the run lands, the sum is divided by twice the run-length code's power of two. This is a plain right shift by `sel+1`, so the average grows one bit wider for each step of the selector. The block then formats the average as an integer or as a left-justified fraction, writes it to a 32-bit data register, sets a ready flag and pulses an interrupt. Software, or the next stage, reads the word with a read strobe, and that strobe clears the ready flag.

Top module: `os_averager`

## Requirements
- R1: The run length is latched from `cnt_sel` at the start trigger. Code 0 means 4 accepted results, 1 means 16, 2 means 64 and 3 means 256. Completion follows the result that makes the count equal to that length.
- R2: The average is the 20-bit sum of the run shifted right by `cnt_sel+1`, truncated. Its width is `13+cnt_sel` bits.
- R3: With the fraction bit clear at the start trigger, `data_out` holds the average right-justified, and every bit above it is zero.
- R4: With the fraction bit set at the start trigger, the average's MSB sits at bit 31 of `data_out`, and every bit below the average is zero.
- R5: `trig_first` clears the sum and the count. `conv_req` is high for one cycle in the cycle after `trig_first`.
- R6: In paced mode, each later `conv_req` comes one cycle after a `trig_next` that arrives while the block waits for a step. A `trig_next` is ignored while a result is outstanding and while the block is idle. A run issues exactly as many requests as its length.
- R7: In burst mode, `conv_req` follows one cycle after each non-final accepted result, with no `trig_next`. `chan_hold` is high from the cycle after `trig_first` until the cycle in which `ready` rises, where it is low.
- R8: In paced mode, `chan_hold` stays low for the whole run.
- R9: In the cycle after the final result is accepted, `data_out` carries the new word, `ready` is high and `irq` is high for exactly one cycle.
- R10: A `trig_first` during a run abandons that run. The new run's result contains only samples accepted after the restart, and `ready` does not rise for the abandoned run.
- R11: A `data_rd` pulse clears `ready` on the next cycle and leaves `data_out` unchanged.
- R12: 256 full-scale samples (4095) do not overflow the sum. The integer result is 0xFFF0 and the fractional result is 0xFFF00000.
- R13: Changes to `cnt_sel`, `burst_en` and `frac_en` after the start trigger have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_first | input | 1 | Start trigger: clear the sum and request the first sample |
| trig_next | input | 1 | Step trigger: request the next sample in paced mode |
| cnt_sel | input | 2 | Run-length code (4, 16, 64, 256 samples) |
| burst_en | input | 1 | Self-sequence the run and hold the converter |
| frac_en | input | 1 | Left-justified fractional output format |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 12 | Conversion result |
| conv_req | output | 1 | One-cycle conversion request to the arbiter |
| chan_hold | output | 1 | Keep other channels off the converter |
| data_rd | input | 1 | Read strobe for the data register |
| data_out | output | 32 | Averaged, formatted result |
| ready | output | 1 | New result available |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 12-bit samples, a 20-bit sum, a 32-bit word and a 2-bit selector. These defaults make all four run lengths reachable, including the 256-sample full-scale run that tests the sum's headroom. A stub converter answers each request after a fixed latency, so the bench sees both mid-run windows: one where a result is outstanding and one where the block waits for a step. Stray step triggers, abandoned runs and mid-run configuration changes are aimed at these windows.

// File: rtl/os_avg_pkg.sv
package os_avg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ARMED = 2'd2
  } run_st_t;
endpackage

// File: rtl/os_avg_seq.sv
module os_avg_seq
  import os_avg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_first,
  input  logic             trig_next,
  input  logic             res_valid,
  input  logic [SEL_W-1:0] cnt_sel,
  input  logic             burst_en,
  input  logic             frac_en,
  input  logic             last_hit,
  output logic [SEL_W-1:0] sel_q,
  output logic             frac_q,
  output logic             clr,
  output logic             add,
  output logic             done,
  output logic             conv_req,
  output logic             chan_hold
);
  run_st_t st_q, st_d;
  logic    req_d, hold_d, burst_q;

  assign clr  = trig_first;
  assign add  = (st_q == ST_WAIT) && res_valid && !trig_first;
  assign done = add && last_hit;

  always_comb begin
    st_d   = st_q;
    req_d  = 1'b0;
    hold_d = chan_hold;
    if (trig_first) begin
      st_d   = ST_WAIT;
      req_d  = 1'b1;
      hold_d = burst_en;
    end else begin
      case (st_q)
        ST_WAIT: begin
          if (add) begin
            if (last_hit) begin
              st_d   = ST_IDLE;
              hold_d = 1'b0;
            end else if (burst_q) begin
              req_d = 1'b1;
            end else begin
              st_d = ST_ARMED;
            end
          end
        end
        ST_ARMED: begin
          if (trig_next) begin
            st_d  = ST_WAIT;
            req_d = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      conv_req  <= 1'b0;
      chan_hold <= 1'b0;
    end else begin
      st_q      <= st_d;
      conv_req  <= req_d;
      chan_hold <= hold_d;
    end
  end

  // configuration is captured only at a start trigger
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      burst_q <= 1'b0;
      frac_q  <= 1'b0;
    end else if (trig_first) begin
      sel_q   <= cnt_sel;
      burst_q <= burst_en;
      frac_q  <= frac_en;
    end
  end

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !chan_hold);
  assert_paced_nohold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_q && !$past(trig_first)) |-> !chan_hold);
endmodule

// File: rtl/os_avg_accum.sv
module os_avg_accum #(
  parameter int SMP_W = 12,
  parameter int ACC_W = 20,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [SMP_W-1:0] din,
  input  logic [SEL_W-1:0] sel,
  output logic [ACC_W-1:0] sum_nxt,
  output logic             last_hit
);
  localparam int NUM_OPT = 1 << SEL_W;
  localparam int CNT_W   = 2 * NUM_OPT + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, tgt;

  assign tgt      = CNT_W'(4) << {sel, 1'b0};
  assign sum_nxt  = acc_q + ACC_W'(din);
  assign last_hit = (cnt_q == tgt - CNT_W'(1));

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (add) begin
      acc_d = sum_nxt;
      cnt_d = last_hit ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    add |-> (sum_nxt >= acc_q));
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < tgt);
endmodule

// File: rtl/os_avg_format.sv
module os_avg_format #(
  parameter int SMP_W = 12,
  parameter int ACC_W = 20,
  parameter int OUT_W = 32,
  parameter int SEL_W = 2
) (
  input  logic [ACC_W-1:0] sum,
  input  logic [SEL_W-1:0] sel,
  input  logic             frac,
  output logic [OUT_W-1:0] word
);
  localparam int NUM_OPT = 1 << SEL_W;

  logic [OUT_W-1:0] cand_int  [NUM_OPT];
  logic [OUT_W-1:0] cand_frac [NUM_OPT];

  for (genvar g = 0; g < NUM_OPT; g++) begin : g_opt
    localparam int SH = g + 1;
    localparam int RW = SMP_W + 1 + g;
    logic [ACC_W-1:0] avg;
    assign avg          = sum >> SH;
    assign cand_int[g]  = {{(OUT_W - ACC_W){1'b0}}, avg};
    assign cand_frac[g] = {avg[RW-1:0], {(OUT_W - RW){1'b0}}};
  end

  assign word = frac ? cand_frac[sel] : cand_int[sel];
endmodule

// File: rtl/os_averager.sv
module os_averager #(
  parameter int SMP_W = 12,
  parameter int ACC_W = 20,
  parameter int OUT_W = 32,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_first,
  input  logic             trig_next,
  input  logic [SEL_W-1:0] cnt_sel,
  input  logic             burst_en,
  input  logic             frac_en,
  input  logic             res_valid,
  input  logic [SMP_W-1:0] res_data,
  output logic             conv_req,
  output logic             chan_hold,
  input  logic             data_rd,
  output logic [OUT_W-1:0] data_out,
  output logic             ready,
  output logic             irq
);
  logic [SEL_W-1:0] sel_q;
  logic             frac_q, clr, add, done, last_hit;
  logic [ACC_W-1:0] sum_nxt;
  logic [OUT_W-1:0] fmt_word, data_d;
  logic             ready_d;

  os_avg_seq #(.SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_first(trig_first), .trig_next(trig_next),
    .res_valid(res_valid), .cnt_sel(cnt_sel), .burst_en(burst_en),
    .frac_en(frac_en), .last_hit(last_hit), .sel_q(sel_q), .frac_q(frac_q),
    .clr(clr), .add(add), .done(done), .conv_req(conv_req),
    .chan_hold(chan_hold)
  );

  os_avg_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W), .SEL_W(SEL_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .add(add), .din(res_data),
    .sel(sel_q), .sum_nxt(sum_nxt), .last_hit(last_hit)
  );

  os_avg_format #(.SMP_W(SMP_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SEL_W(SEL_W))
    u_fmt (.sum(sum_nxt), .sel(sel_q), .frac(frac_q), .word(fmt_word));

  always_comb begin
    data_d  = done ? fmt_word : data_out;
    ready_d = ready;
    if (done)         ready_d = 1'b1;
    else if (data_rd) ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      ready    <= 1'b0;
      irq      <= 1'b0;
    end else begin
      data_out <= data_d;
      ready    <= ready_d;
      irq      <= done;
    end
  end

  assert_irq_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready);
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_ready_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> irq);
  assert_rd_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !done) |=> !ready);
  assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(data_out));
endmodule

// File: tb/os_averager_test.sv
module os_averager_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic        clk, rst_n;
  logic        trig_first, trig_next, burst_en, frac_en, res_valid, data_rd;
  logic [1:0]  cnt_sel;
  logic [11:0] res_data, stub_v;
  logic        conv_req, chan_hold, ready, irq;
  logic [31:0] data_out;

  int unsigned n_vec, n_bad, req_cnt, irq_cnt, stub_n, pat;
  longint      stub_sum;
  logic [2:0]  pend;
  bit          finished;

  os_averager uut (
    .clk(clk), .rst_n(rst_n), .trig_first(trig_first), .trig_next(trig_next),
    .cnt_sel(cnt_sel), .burst_en(burst_en), .frac_en(frac_en),
    .res_valid(res_valid), .res_data(res_data), .conv_req(conv_req),
    .chan_hold(chan_hold), .data_rd(data_rd), .data_out(data_out),
    .ready(ready), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // stub converter: answers each request after LAT cycles
  always_comb stub_v = (pat == 0) ? 12'hFFF : 12'((stub_n * pat + 7 * pat + 100) % 4096);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; res_valid <= 1'b0; res_data <= '0; stub_n <= 0; stub_sum <= 0;
    end else begin
      res_valid <= 1'b0;
      if (conv_req) pend <= 3'(LAT);
      else if (pend != 0) begin
        pend <= pend - 3'd1;
        if (pend == 3'd1) begin
          res_valid <= 1'b1;
          res_data  <= stub_v;
          stub_n    <= stub_n + 1;
          stub_sum  <= stub_sum + longint'(stub_v);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (conv_req) req_cnt <= req_cnt + 1;
    if (irq)      irq_cnt <= irq_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int k, input bit burst, input bit frac, input int p,
                     input bit twist, input bit noise);
    int n;
    longint base_s, s;
    int unsigned base_r, base_i;
    int guard, hold_bad;
    bit pendn;
    logic [31:0] avg, exp, snap;
    n = 4 << (2 * k);
    @(negedge clk);
    pat = p; cnt_sel = k[1:0]; burst_en = burst; frac_en = frac; trig_first = 1'b1;
    base_s = stub_sum; base_r = req_cnt; base_i = irq_cnt;
    @(negedge clk);
    trig_first = 1'b0;
    check(conv_req == 1'b1, "R5 request after start", 32'(conv_req), 32'd1);
    if (twist) begin // R13: change config mid-run
      cnt_sel = ~k[1:0]; burst_en = !burst; frac_en = !frac;
    end
    if (noise) trig_next = 1'b1; // R6: step while a result is outstanding
    pendn = 0; guard = 0; hold_bad = 0;
    while (!ready && guard < 6000) begin
      if (chan_hold !== burst) hold_bad++;
      @(negedge clk);
      guard++;
      trig_next = 1'b0;
      if (pendn) begin trig_next = !ready; pendn = 0; end
      if (res_valid && !burst) pendn = 1;
    end
    check(ready == 1'b1, "R9 ready set", 32'(ready), 32'd1);
    check(irq == 1'b1, "R9 irq with ready", 32'(irq), 32'd1);
    check(chan_hold == 1'b0, "R7 hold released at completion", 32'(chan_hold), 32'd0);
    check(hold_bad == 0, burst ? "R7 hold during burst run" : "R8 hold low in paced run",
          32'(hold_bad), 32'd0);
    s   = stub_sum - base_s;
    avg = 32'(s >> (k + 1));
    exp = frac ? (avg << (19 - k)) : avg;
    check(data_out == exp, frac ? "R4 R2 fractional average" : "R3 R2 integer average",
          data_out, exp);
    check(req_cnt - base_r == n, burst ? "R7 R1 request count" : "R6 R1 request count",
          req_cnt - base_r, 32'(n));
    snap = data_out;
    @(negedge clk);
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    check(ready == 1'b0, "R11 read clears ready", 32'(ready), 32'd0);
    check(data_out == snap, "R11 data kept after read", data_out, snap);
    check(irq_cnt - base_i == 1, "R9 single irq", irq_cnt - base_i, 32'd1);
  endtask

  task automatic test_reset();
    check(ready == 1'b0 && irq == 1'b0, "R9 reset flags", {30'd0, ready, irq}, 32'd0);
    check(data_out == 32'd0, "R3 reset data", data_out, 32'd0);
    check(conv_req == 1'b0 && chan_hold == 1'b0, "R7 reset outputs",
          {30'd0, conv_req, chan_hold}, 32'd0);
  endtask

  task automatic test_restart();
    int seen, guard;
    @(negedge clk);
    pat = 21; cnt_sel = 2'd0; burst_en = 1'b0; frac_en = 1'b0; trig_first = 1'b1;
    @(negedge clk);
    trig_first = 1'b0;
    seen = 0; guard = 0;
    while (seen < 2 && guard < 100) begin
      @(negedge clk);
      guard++;
      trig_next = 1'b0;
      if (res_valid) begin
        seen++;
        if (seen < 2) begin
          @(negedge clk);
          trig_next = 1'b1;
        end
      end
    end
    trig_next = 1'b0;
    repeat (2) @(negedge clk);
    check(ready == 1'b0, "R10 no ready from abandoned run", 32'(ready), 32'd0);
    run(0, 0, 0, 33, 0, 0); // R10: restart while the block waits for a step
  endtask

  task automatic test_idle_step();
    @(negedge clk);
    trig_next = 1'b1;
    @(negedge clk);
    trig_next = 1'b0;
    check(conv_req == 1'b0, "R6 step ignored when idle", 32'(conv_req), 32'd0);
    @(negedge clk);
    check(conv_req == 1'b0, "R6 no late request when idle", 32'(conv_req), 32'd0);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; req_cnt = 0; irq_cnt = 0; pat = 1; finished = 0;
    rst_n = 1'b0; trig_first = 0; trig_next = 0; burst_en = 0; frac_en = 0;
    data_rd = 0; cnt_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run(0, 0, 0, 5, 0, 0);   // R1 R3 paced, 4 samples
    run(1, 0, 1, 9, 0, 1);   // R4 R6 paced fractional with stray step
    run(2, 1, 0, 13, 0, 0);  // R7 burst, 64 samples
    run(3, 1, 1, 0, 0, 0);   // R12 full-scale fractional, 256
    run(3, 0, 0, 0, 0, 0);   // R12 full-scale integer, 256
    run(1, 1, 0, 3, 1, 0);   // R13 config changed mid-run
    run(0, 0, 1, 11, 1, 0);  // R13 paced with config changed
    test_restart();          // R10
    test_idle_step();        // R6
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule